// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block times a successive-approximation analog-to-digital converter. A start request latches a 4-bit prescaler field and raises a busy flag. While busy, a prescaler divides the system clock into converter clock ticks. No ticks are made while idle, so the converter logic stays frozen and draws no switching power. Each conversion walks a fixed schedule of 17 converter cycles: one reset cycle, seven sampling cycles with the analog input switch closed, eight bit-decision cycles, and one cycle that loads the result register.

During the decision cycles the block drives a trial code to an external DAC. It reads back one comparator bit and settles the code from the most significant bit down. A halt/idle input powers the sequence down in place. When the input drops, the conversion restarts from its reset cycle, and the result it then loads is flagged invalid because the held sample was lost. Software sees a one-cycle done pulse and a sticky done flag. A read strobe clears the flag. The result register has no write path.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion accepted by `start` keeps `busy` high for exactly 17 converter ticks (`adc_tick` pulses), which is 17 × D system-clock cycles for an effective divide D, after which `busy` falls.
- R2: `sample_en` is high for exactly 7 converter cycles (7 × D system cycles) per uninterrupted conversion and is low in every other cycle, including every idle cycle.
- R3: The comparator input is read as 1 = "trial code ≤ analog input, keep the bit". The code is settled MSB first, so a comparator that follows an input value V yields `result` = V. `result` changes only on the load edge and holds its value otherwise, including across reads.
- R4: `div_val` is sampled only on the accepted start edge. A value of 0 acts as divide-by-1, so D = max(`div_val`, 1).
- R5: While `busy` is low, `adc_tick` stays low.
- R6: If `halt` is high during a conversion, ticks stop and the sequence holds. One system cycle after `halt` falls, the sequence restarts at the reset cycle and then runs a full 17 × D cycles. The loaded `result_invalid` is 1. An uninterrupted conversion loads `result_invalid` = 0.
- R7: A `start` while `busy` is high is ignored. It neither restarts the sequence nor changes the latched divide.
- R8: `done_pulse` is high for exactly the one system cycle after the load edge, which is also the first cycle with `busy` low. `done_flag` rises on the same edge and stays set until a `bus_rd` cycle clears it. A load in the same cycle as `bus_rd` leaves the flag set.
- R9: After reset, `busy`, `sample_en`, `adc_tick`, `done_pulse`, `done_flag`, `result_invalid` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start-conversion write strobe |
| div_val | input | 4 | Prescaler divide field (0 means 1) |
| halt | input | 1 | Halt/idle power-down request, level |
| cmp_in | input | 1 | Comparator result for the current trial code |
| bus_rd | input | 1 | Read strobe of the result register; clears done flag |
| busy | output | 1 | Conversion in progress; gates the converter clock |
| adc_tick | output | 1 | Converter clock enable, one system cycle per converter cycle |
| sample_en | output | 1 | Analog input switch enable |
| dac_code | output | 8 | Trial code driven to the DAC array |
| result | output | 8 | Read-only conversion result |
| result_invalid | output | 1 | Loaded result came from a restarted, corrupted sample |
| done_pulse | output | 1 | One-cycle pulse at result load |
| done_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The bench builds the block with its default parameters: an 8-bit result, seven sampling cycles and a 4-bit divide field. With these values the whole divide range, from 0 (divide-by-1) through 15, can be exercised, and the bench covers both ends directly along with random divides in between. The bench comparator tracks an analog value, which puts the all-zeros and all-ones codes within reach. A halt inserted mid-sampling checks the restart length and the invalid flag. A start with a different divide during a conversion checks that the latched divide and the running sequence are kept.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_RESET,
        PH_SAMPLE,
        PH_CONV,
        PH_LOAD
    } phase_t;

    typedef struct packed {
        logic busy;
        logic pd;
        logic corrupt;
    } seq_state_t;

    function automatic int total_steps(input int n_sample, input int n_bits);
        return 1 + n_sample + n_bits + 1;
    endfunction

    function automatic phase_t phase_of(input int step, input int n_sample, input int n_bits);
        if (step == 0)
            return PH_RESET;
        if (step <= n_sample)
            return PH_SAMPLE;
        if (step <= n_sample + n_bits)
            return PH_CONV;
        return PH_LOAD;
    endfunction

    // bit under trial for a conversion step, MSB first
    function automatic int bit_of(input int step, input int n_sample, input int n_bits);
        return n_sample + n_bits - step;
    endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             clr,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (div_q == '0) ? '0 : div_q - 1'b1;
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            if (load)
                div_q <= div_in;
            if (clr)
                cnt_q <= '0;
            else if (run)
                cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: counter never passes the latched divide limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        !load |-> cnt_q <= lim);

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int STEP_W = 5,
    parameter int LAST   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    input  logic              tick,
    output logic              start_acc,
    output logic              restart,
    output logic              run,
    output seq_state_t        st,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LAST);

    seq_state_t        st_q;
    logic [STEP_W-1:0] step_q;

    assign start_acc = start && !st_q.busy;
    assign restart   = st_q.busy && st_q.pd && !halt;
    assign run       = st_q.busy && !st_q.pd && !halt;
    assign st        = st_q;
    assign step      = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            step_q <= '0;
        end else if (start_acc) begin
            st_q.busy    <= 1'b1;
            st_q.pd      <= 1'b0;
            st_q.corrupt <= 1'b0;
            step_q       <= '0;
        end else if (st_q.busy) begin
            if (halt) begin
                st_q.pd      <= 1'b1;
                st_q.corrupt <= 1'b1;
            end else if (st_q.pd) begin
                st_q.pd <= 1'b0;
                step_q  <= '0;
            end else if (tick) begin
                if (step_q == LAST_STEP) begin
                    st_q.busy <= 1'b0;
                    step_q    <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // R1: busy only ends on the tick that closes the last step
    a_r1_end_on_last: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.busy) |-> $past(tick) && ($past(step_q) == LAST_STEP));

    // R6: a halt during a conversion powers the sequence down
    a_r6_halt_pd: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && halt && !start |=> st_q.pd && st_q.corrupt);

    // R5: idle sequencer sits at step zero
    a_r5_idle_step: assert property (@(posedge clk) disable iff (rst)
        !st_q.busy |-> step_q == '0);

    // R7: a start while busy never restarts the step counter
    a_r7_ignore_start: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && !st_q.pd && !halt && !tick |=> $stable(step_q));

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
    import sar_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int N_SAMPLE = 7,
    parameter int STEP_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    input  logic              cmp_in,
    input  logic              corrupt,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] result,
    output logic              result_invalid,
    output logic              done_pulse,
    output logic              done_flag
);
    logic [DATA_W-1:0] sar_q;
    logic [DATA_W-1:0] sar_n;
    logic [DATA_W-1:0] result_q;
    logic              inval_q;
    logic              done_p_q;
    logic              done_f_q;
    phase_t            ph;
    int                bi;
    logic              is_load;

    assign ph      = phase_of(int'(step), N_SAMPLE, DATA_W);
    assign bi      = bit_of(int'(step), N_SAMPLE, DATA_W);
    assign is_load = tick && (ph == PH_LOAD);

    always_comb begin
        sar_n = sar_q;
        for (int b = 0; b < DATA_W; b++) begin
            if (b == bi && !cmp_in)
                sar_n[b] = 1'b0;
            if (b == bi - 1)
                sar_n[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q    <= '0;
            result_q <= '0;
            inval_q  <= 1'b0;
            done_p_q <= 1'b0;
            done_f_q <= 1'b0;
        end else begin
            done_p_q <= 1'b0;
            if (clr) begin
                sar_q <= '0;
            end else if (tick) begin
                case (ph)
                    PH_SAMPLE: if (int'(step) == N_SAMPLE)
                                   sar_q <= {1'b1, {(DATA_W-1){1'b0}}};
                    PH_CONV:   sar_q <= sar_n;
                    default:   ;
                endcase
            end
            if (is_load) begin
                result_q <= sar_q;
                inval_q  <= corrupt;
                done_p_q <= 1'b1;
                done_f_q <= 1'b1;
            end else if (bus_rd) begin
                done_f_q <= 1'b0;
            end
        end
    end

    assign dac_code       = sar_q;
    assign result         = result_q;
    assign result_invalid = inval_q;
    assign done_pulse     = done_p_q;
    assign done_flag      = done_f_q;

    // R3: result holds except on the load edge
    a_r3_result_stable: assert property (@(posedge clk) disable iff (rst)
        !is_load |=> $stable(result_q));

    // R8: the done pulse lasts one cycle and comes with the flag
    a_r8_pulse_flag: assert property (@(posedge clk) disable iff (rst)
        done_p_q |-> done_f_q);
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        done_p_q |=> !done_p_q);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int N_SAMPLE = 7,
    parameter int DIV_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              halt,
    input  logic              cmp_in,
    input  logic              bus_rd,
    output logic              busy,
    output logic              adc_tick,
    output logic              sample_en,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] result,
    output logic              result_invalid,
    output logic              done_pulse,
    output logic              done_flag
);
    localparam int TOTAL  = total_steps(N_SAMPLE, DATA_W);
    localparam int STEP_W = $clog2(TOTAL);

    logic              start_acc;
    logic              restart;
    logic              run;
    logic              tick;
    seq_state_t        st;
    logic [STEP_W-1:0] step;
    phase_t            ph;

    sar_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .load   (start_acc),
        .div_in (div_val),
        .clr    (start_acc || restart),
        .run    (run),
        .tick   (tick)
    );

    sar_sequencer #(.STEP_W(STEP_W), .LAST(TOTAL - 1)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .halt      (halt),
        .tick      (tick),
        .start_acc (start_acc),
        .restart   (restart),
        .run       (run),
        .st        (st),
        .step      (step)
    );

    sar_datapath #(.DATA_W(DATA_W), .N_SAMPLE(N_SAMPLE), .STEP_W(STEP_W)) u_dp (
        .clk            (clk),
        .rst            (rst),
        .clr            (start_acc || restart),
        .tick           (tick),
        .step           (step),
        .cmp_in         (cmp_in),
        .corrupt        (st.corrupt),
        .bus_rd         (bus_rd),
        .dac_code       (dac_code),
        .result         (result),
        .result_invalid (result_invalid),
        .done_pulse     (done_pulse),
        .done_flag      (done_flag)
    );

    assign ph        = phase_of(int'(step), N_SAMPLE, DATA_W);
    assign busy      = st.busy;
    assign adc_tick  = tick;
    assign sample_en = run && (ph == PH_SAMPLE);

    // R2: analog switch closes only inside a running conversion
    a_r2_sample_busy: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy && !halt);

    // R5: no converter ticks while idle
    a_r5_no_idle_tick: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !adc_tick);

endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] div_val = '0;
    logic       halt = 1'b0;
    logic       cmp_in;
    logic       bus_rd = 1'b0;
    logic       busy, adc_tick, sample_en, result_invalid, done_pulse, done_flag;
    logic [7:0] dac_code, result;
    logic [7:0] vin = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // comparator model: keep the trial bit when the code does not exceed the input
    assign cmp_in = (dac_code <= vin);

    sar_seq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .div_val(div_val), .halt(halt),
        .cmp_in(cmp_in), .bus_rd(bus_rd), .busy(busy), .adc_tick(adc_tick),
        .sample_en(sample_en), .dac_code(dac_code), .result(result),
        .result_invalid(result_invalid), .done_pulse(done_pulse), .done_flag(done_flag)
    );

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic conv(input int d, input int v, input int halt_at, input int extra_at, input bit rd_hold);
        int nb, ns, nt, it, exp_b;
        @(negedge clk);
        vin = v[7:0]; div_val = d[3:0]; start = 1'b1; bus_rd = rd_hold;
        @(negedge clk);
        start = 1'b0;
        nb = 0; ns = 0; nt = 0; it = 0;
        while (busy && it < 5000) begin
            nb++;
            if (sample_en) ns++;
            if (adc_tick) nt++;
            if (halt_at >= 0 && it == halt_at) halt = 1'b1;
            if (halt_at >= 0 && it == halt_at + 5) halt = 1'b0;
            if (it == extra_at) begin start = 1'b1; div_val = 4'd9; end
            else start = 1'b0;
            it++;
            @(negedge clk);
        end
        start = 1'b0;
        exp_b = (halt_at >= 0) ? halt_at + 6 + 17 * eff_div(d) : 17 * eff_div(d);
        chk(it < 5000, "R1", "conversion ended", it, exp_b);
        chk(nb == exp_b, (halt_at >= 0) ? "R6" : ((extra_at >= 0) ? "R7" : "R1"), "busy cycles", nb, exp_b);
        if (halt_at < 0) begin
            chk(nt == 17, "R1", "tick count", nt, 17);
            chk(ns == 7 * eff_div(d), "R2", "sample cycles", ns, 7 * eff_div(d));
        end
        chk(result == v[7:0], "R3", "result value", int'(result), v);
        chk(result_invalid == (halt_at >= 0), "R6", "invalid flag", int'(result_invalid), int'(halt_at >= 0));
        chk(done_pulse == 1'b1, "R8", "done pulse at load", int'(done_pulse), 1);
        chk(done_flag == 1'b1, "R8", "done flag set (load wins)", int'(done_flag), 1);
        @(negedge clk);
        chk(done_pulse == 1'b0, "R8", "done pulse one cycle", int'(done_pulse), 0);
        chk(adc_tick == 1'b0 && sample_en == 1'b0, "R5", "idle tick/sample", int'(adc_tick) + int'(sample_en), 0);
        if (rd_hold) begin
            chk(done_flag == 1'b0, "R8", "flag cleared by held read", int'(done_flag), 0);
            bus_rd = 1'b0;
        end else begin
            chk(done_flag == 1'b1, "R8", "flag sticky", int'(done_flag), 1);
            bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
            chk(done_flag == 1'b0, "R8", "flag cleared by read", int'(done_flag), 0);
        end
        chk(result == v[7:0], "R3", "result holds after read", int'(result), v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idle_ticks;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy == 0 && sample_en == 0 && adc_tick == 0, "R9", "reset control outputs",
            int'(busy) + int'(sample_en) + int'(adc_tick), 0);
        chk(done_pulse == 0 && done_flag == 0 && result_invalid == 0, "R9", "reset flags",
            int'(done_pulse) + int'(done_flag) + int'(result_invalid), 0);
        chk(result == 8'd0, "R9", "reset result", int'(result), 0);
        // R5 idle window
        idle_ticks = 0;
        repeat (20) begin
            if (adc_tick || sample_en) idle_ticks++;
            @(negedge clk);
        end
        chk(idle_ticks == 0, "R5", "idle ticks", idle_ticks, 0);
        // R4 directed divides, R3 corner codes
        conv(0, 8'hA5, -1, -1, 1'b0);
        conv(1, 8'h00, -1, -1, 1'b0);
        conv(15, 8'hFF, -1, -1, 1'b0);
        conv(6, 8'h3C, -1, -1, 1'b0);
        // R7 start while busy with another divide
        conv(3, 8'h81, -1, 10, 1'b0);
        // R8 read held across the load edge
        conv(2, 8'h5A, -1, -1, 1'b1);
        // R6 halt in the middle of sampling, then a clean one
        conv(4, 8'hC3, 30, -1, 1'b0);
        conv(4, 8'h17, -1, -1, 1'b0);
        // random mix
        for (int k = 0; k < 20; k++) begin
            conv(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), -1, -1, 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule